// File: doc/BRIEF.md
# Transmit mailbox arbiter for a CAN controller

This block decides which of 32 message mailboxes is handed next to a CAN frame transmitter. Each mailbox has an enable bit, a direction bit and a 6-bit transmit priority. Each mailbox also has one pending-request bit, which software sets by writing ones. A mailbox competes only when it is enabled, set for transmit and requesting. The contest goes to the largest priority value. When two priorities are equal, the higher mailbox number wins.

The winner is presented as a registered index with a valid flag. The transmitter takes it with a start pulse and ends the frame with a done pulse or an abort pulse. At done, the mailbox's request bit drops and its acknowledge bit rises in the same cycle. If that mailbox's interrupt mask bit is set, a global mailbox interrupt flag is also raised. Acknowledge bits are cleared by writing ones, and the global flag has its own clear strobe. Frame encoding, bus arbitration and message storage sit outside the block.

Top module: `txmb_arbiter`

## Requirements
- R1: After synchronous reset, every request bit, every acknowledge bit, the global flag, `pick_valid`, `pick_idx` and `xmit_busy` are zero.
- R2: A cycle with `req_set_we` high sets each request bit whose `req_set_data` bit is 1. Bits written as 0 keep their value, so this write can never clear a request.
- R3: A mailbox qualifies only when its enable bit is 1, its direction bit is 0 (0 means transmit, 1 means receive) and its request bit is 1.
- R4: Among qualifying mailboxes, the one with the numerically largest priority value (0 to 63) is picked.
- R5: When qualifying mailboxes share the largest priority, the highest-numbered of them is picked.
- R6: While idle, the pick registers follow the qualifying set one clock later. With nothing qualifying, `pick_valid` is 0 and `pick_idx` keeps the last winner.
- R7: A start pulse while idle with `pick_valid` high makes `xmit_busy` 1 on the next edge. Through the whole frame, `pick_idx` and `pick_valid` stay frozen, and requests that arrive mid-frame are weighed only after the frame ends.
- R8: Done during a frame clears that mailbox's request bit and sets its acknowledge bit on the same edge. On that edge `xmit_busy` returns to 0, and `pick_valid` is 0 for one cycle before the next selection.
- R9: A cycle with `ack_clr_we` high clears each acknowledge bit whose `ack_clr_data` bit is 1, and bits written as 0 are unchanged. If the same bit is being set by done in that cycle, it ends up set.
- R10: Done sets `gflag` only when `irq_mask` for the finishing mailbox is 1. `gflag_clr` clears it, and a set in the same cycle wins.
- R11: Abort during a frame returns `xmit_busy` to 0, leaves the request bit pending and the acknowledge bit clear, and the mailbox competes again.
- R12: Start is ignored while `pick_valid` is 0, and done and abort are ignored while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mb_enable | input | 32 | Per-mailbox enable |
| mb_dir_rx | input | 32 | Per-mailbox direction, 1 = receive |
| mb_prio | input | 192 | Six priority bits per mailbox, mailbox i at bits 6i+5..6i |
| req_set_we | input | 1 | Request-set write strobe |
| req_set_data | input | 32 | Ones set request bits |
| ack_clr_we | input | 1 | Acknowledge-clear write strobe |
| ack_clr_data | input | 32 | Ones clear acknowledge bits |
| irq_mask | input | 32 | Per-mailbox interrupt mask |
| gflag_clr | input | 1 | Clears the global mailbox flag |
| xmit_start | input | 1 | Transmitter takes the presented winner |
| xmit_done | input | 1 | Frame sent successfully |
| xmit_abort | input | 1 | Frame given up |
| pick_valid | output | 1 | A winner is presented |
| pick_idx | output | 5 | Winning mailbox number |
| xmit_busy | output | 1 | A frame is in progress |
| req_pending | output | 32 | Request bits |
| ack_status | output | 32 | Acknowledge bits |
| gflag | output | 1 | Global mailbox interrupt flag |

## Verification
The properties assume that start, done and abort are single-cycle pulses, and that the transmitter reports a frame's end only for the mailbox it took. The stimulus drives each handshake for exactly one cycle, always between rising edges. It alters enables, directions and priorities only while the arbiter is idle, apart from one deliberate request raised in mid-frame to test the freeze. Same-cycle collisions, such as done against an acknowledge clear, are produced on purpose in the directed scenarios.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
    localparam int MB_COUNT   = 32;
    localparam int PRIO_W     = 6;
    localparam int IDX_W      = $clog2(MB_COUNT);
    localparam int LEAF_COUNT = 1 << IDX_W;

    typedef logic [MB_COUNT-1:0] mb_vec_t;
    typedef logic [PRIO_W-1:0]   prio_t;
    typedef logic [IDX_W-1:0]    idx_t;

    typedef struct packed {
        logic  valid;
        prio_t prio;
        idx_t  idx;
    } cand_t;

    typedef enum logic {ST_IDLE, ST_SEND} tx_state_e;

    // lo covers lower mailbox numbers than hi; hi wins a priority tie
    function automatic cand_t cand_merge(input cand_t lo, input cand_t hi);
        if (!hi.valid)               return lo;
        else if (!lo.valid)          return hi;
        else if (hi.prio >= lo.prio) return hi;
        else                         return lo;
    endfunction
endpackage

// File: rtl/txmb_pick.sv
module txmb_pick import txmb_pkg::*; (
    input  mb_vec_t                     qual,
    input  logic [MB_COUNT*PRIO_W-1:0]  prio_flat,
    output cand_t                       best
);
    genvar lv, k;
    generate
        for (lv = 0; lv <= IDX_W; lv++) begin : g_lvl
            cand_t nodes [LEAF_COUNT >> lv];
            for (k = 0; k < (LEAF_COUNT >> lv); k++) begin : g_node
                if (lv == 0) begin : g_leaf
                    if (k < MB_COUNT) begin : g_real
                        assign nodes[k] = '{valid: qual[k],
                                            prio:  prio_flat[k*PRIO_W +: PRIO_W],
                                            idx:   idx_t'(k)};
                    end else begin : g_pad
                        assign nodes[k] = '0;
                    end
                end else begin : g_merge
                    assign nodes[k] = cand_merge(g_lvl[lv-1].nodes[2*k],
                                                 g_lvl[lv-1].nodes[2*k+1]);
                end
            end
        end
    endgenerate

    assign best = g_lvl[IDX_W].nodes[0];
endmodule

// File: rtl/txmb_regs.sv
module txmb_regs import txmb_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  logic    set_we,
    input  mb_vec_t set_data,
    input  logic    clr_we,
    input  mb_vec_t clr_data,
    input  logic    done_pulse,
    input  idx_t    done_idx,
    input  mb_vec_t irq_mask,
    input  logic    gflag_clr,
    output mb_vec_t req_q,
    output mb_vec_t ack_q,
    output logic    gflag_q
);
    mb_vec_t done_hot;
    mb_vec_t req_d;
    mb_vec_t ack_d;
    logic    gflag_d;

    always_comb begin
        done_hot = done_pulse ? (mb_vec_t'(1) << done_idx) : '0;
        // a fresh request written alongside completion survives
        req_d    = (req_q & ~done_hot) | (set_we ? set_data : '0);
        // completion wins over a same-cycle clear
        ack_d    = (ack_q & ~(clr_we ? clr_data : '0)) | done_hot;
        gflag_d  = (gflag_q & ~gflag_clr) | (|(done_hot & irq_mask));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q   <= '0;
            ack_q   <= '0;
            gflag_q <= 1'b0;
        end else begin
            req_q   <= req_d;
            ack_q   <= ack_d;
            gflag_q <= gflag_d;
        end
    end
endmodule

// File: rtl/txmb_seq.sv
module txmb_seq import txmb_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  cand_t best,
    input  logic  start_i,
    input  logic  done_i,
    input  logic  abort_i,
    output logic  win_valid_q,
    output idx_t  win_idx_q,
    output logic  busy_o,
    output logic  done_pulse_o
);
    tx_state_e st_q;

    assign busy_o       = (st_q == ST_SEND);
    assign done_pulse_o = busy_o & done_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            win_valid_q <= 1'b0;
            win_idx_q   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i && win_valid_q) begin
                        st_q <= ST_SEND;
                    end else begin
                        win_valid_q <= best.valid;
                        if (best.valid) win_idx_q <= best.idx;
                    end
                end
                ST_SEND: begin
                    if (done_i || abort_i) begin
                        st_q        <= ST_IDLE;
                        win_valid_q <= 1'b0;   // force a fresh selection
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txmb_arbiter.sv
module txmb_arbiter import txmb_pkg::*; (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [MB_COUNT-1:0]         mb_enable,
    input  logic [MB_COUNT-1:0]         mb_dir_rx,
    input  logic [MB_COUNT*PRIO_W-1:0]  mb_prio,
    input  logic                        req_set_we,
    input  logic [MB_COUNT-1:0]         req_set_data,
    input  logic                        ack_clr_we,
    input  logic [MB_COUNT-1:0]         ack_clr_data,
    input  logic [MB_COUNT-1:0]         irq_mask,
    input  logic                        gflag_clr,
    input  logic                        xmit_start,
    input  logic                        xmit_done,
    input  logic                        xmit_abort,
    output logic                        pick_valid,
    output logic [IDX_W-1:0]            pick_idx,
    output logic                        xmit_busy,
    output logic [MB_COUNT-1:0]         req_pending,
    output logic [MB_COUNT-1:0]         ack_status,
    output logic                        gflag
);
    mb_vec_t qual;
    cand_t   best;
    logic    done_pulse;

    assign qual = mb_enable & ~mb_dir_rx & req_pending;

    txmb_pick u_pick (
        .qual      (qual),
        .prio_flat (mb_prio),
        .best      (best)
    );

    txmb_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .best         (best),
        .start_i      (xmit_start),
        .done_i       (xmit_done),
        .abort_i      (xmit_abort),
        .win_valid_q  (pick_valid),
        .win_idx_q    (pick_idx),
        .busy_o       (xmit_busy),
        .done_pulse_o (done_pulse)
    );

    txmb_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .set_we     (req_set_we),
        .set_data   (req_set_data),
        .clr_we     (ack_clr_we),
        .clr_data   (ack_clr_data),
        .done_pulse (done_pulse),
        .done_idx   (pick_idx),
        .irq_mask   (irq_mask),
        .gflag_clr  (gflag_clr),
        .req_q      (req_pending),
        .ack_q      (ack_status),
        .gflag_q    (gflag)
    );
endmodule

// File: rtl/txmb_arbiter_chk.sv
module txmb_arbiter_chk import txmb_pkg::*; (
    input logic                clk,
    input logic                rst,
    input logic                xmit_start,
    input logic                xmit_done,
    input logic [MB_COUNT-1:0] irq_mask,
    input logic                pick_valid,
    input logic [IDX_W-1:0]    pick_idx,
    input logic                xmit_busy,
    input logic [MB_COUNT-1:0] req_pending,
    input logic [MB_COUNT-1:0] ack_status,
    input logic                gflag
);
    AST_REQ_NO_SPONTANEOUS_DROP: assert property (@(posedge clk) disable iff (rst)
        (|($past(req_pending) & ~req_pending)) |-> $past(xmit_busy && xmit_done)); // R2

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        $rose(xmit_busy) |-> $past(xmit_start && pick_valid)); // R7

    AST_PICK_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (xmit_busy && $past(xmit_busy)) |-> ($stable(pick_idx) && pick_valid)); // R7

    AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (xmit_busy && xmit_done) |=> (!xmit_busy && !pick_valid)); // R8

    AST_DONE_SETS_ACK: assert property (@(posedge clk) disable iff (rst)
        (xmit_busy && xmit_done) |=> ack_status[$past(pick_idx)]); // R8

    AST_ACK_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (|(ack_status & ~$past(ack_status))) |-> $past(xmit_busy && xmit_done)); // R8

    AST_GFLAG_MASKED: assert property (@(posedge clk) disable iff (rst)
        $rose(gflag) |-> $past(xmit_busy && xmit_done && irq_mask[pick_idx])); // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!xmit_busy && !pick_valid) |=> !xmit_busy); // R12
endmodule

bind txmb_arbiter txmb_arbiter_chk u_chk (.*);

// File: tb/txmb_arbiter_bench.sv
module txmb_arbiter_bench;
    import txmb_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                       clk = 1'b0;
    logic                       rst;
    logic [MB_COUNT-1:0]        mb_enable, mb_dir_rx, irq_mask;
    logic [MB_COUNT*PRIO_W-1:0] mb_prio;
    logic                       req_set_we, ack_clr_we, gflag_clr;
    logic [MB_COUNT-1:0]        req_set_data, ack_clr_data;
    logic                       xmit_start, xmit_done, xmit_abort;
    logic                       pick_valid, xmit_busy, gflag;
    logic [IDX_W-1:0]           pick_idx;
    logic [MB_COUNT-1:0]        req_pending, ack_status;
    logic [PRIO_W-1:0]          prio_tb [MB_COUNT];

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < MB_COUNT; i++) mb_prio[i*PRIO_W +: PRIO_W] = prio_tb[i];
    end

    txmb_arbiter u_txmb_arbiter (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset;
        rst = 1'b1;
        mb_enable = '1; mb_dir_rx = 32'hFFFF_FF00; irq_mask = '1;
        req_set_we = 0; req_set_data = '0; ack_clr_we = 0; ack_clr_data = '0;
        gflag_clr = 0; xmit_start = 0; xmit_done = 0; xmit_abort = 0;
        for (int i = 0; i < MB_COUNT; i++) prio_tb[i] = '0;
        step(2);
        rst = 1'b0;
        step(1);
    endtask

    task automatic set_req(input logic [31:0] m);
        req_set_we = 1; req_set_data = m; step(1); req_set_we = 0; req_set_data = '0;
    endtask

    task automatic clr_ack(input logic [31:0] m);
        ack_clr_we = 1; ack_clr_data = m; step(1); ack_clr_we = 0; ack_clr_data = '0;
    endtask

    task automatic pulse_start; xmit_start = 1; step(1); xmit_start = 0; endtask
    task automatic pulse_done;  xmit_done  = 1; step(1); xmit_done  = 0; endtask
    task automatic pulse_abort; xmit_abort = 1; step(1); xmit_abort = 0; endtask

    task automatic t_reset;
        do_reset();
        check("R1 pick_valid", pick_valid, 0);
        check("R1 pick_idx", pick_idx, 0);
        check("R1 busy", xmit_busy, 0);
        check("R1 req", req_pending, 0);
        check("R1 ack", ack_status, 0);
        check("R1 gflag", gflag, 0);
    endtask

    task automatic t_set;
        do_reset();
        set_req(32'h05);
        check("R2 set", req_pending, 32'h05);
        set_req(32'h02);
        check("R2 zeros keep", req_pending, 32'h07);
        set_req(32'h00);
        check("R2 zero write", req_pending, 32'h07);
    endtask

    task automatic t_prio;
        do_reset();
        prio_tb[1] = 10; prio_tb[3] = 40; prio_tb[5] = 20;
        set_req(32'h2A); step(1);
        check("R4 valid", pick_valid, 1);
        check("R4 highest prio", pick_idx, 3);
        prio_tb[0] = 63;
        set_req(32'h01); step(1);
        check("R4 max value", pick_idx, 0);
    endtask

    task automatic t_tie;
        do_reset();
        prio_tb[2] = 7; prio_tb[6] = 7; prio_tb[4] = 3;
        set_req(32'h54); step(1);
        check("R5 tie high index", pick_idx, 6);
    endtask

    task automatic t_qual;
        do_reset();
        mb_enable[6] = 0;
        set_req(32'h40); step(1);
        check("R3 disabled", pick_valid, 0);
        set_req(32'h0010_0000); step(1);
        check("R3 receive dir", pick_valid, 0);
        mb_enable[6] = 1; step(1);
        check("R3 enabled valid", pick_valid, 1);
        check("R3 enabled idx", pick_idx, 6);
        mb_enable[6] = 0; step(1);
        check("R6 none valid", pick_valid, 0);
        check("R6 idx held", pick_idx, 6);
    endtask

    task automatic t_frame;
        do_reset();
        prio_tb[2] = 5; prio_tb[4] = 9;
        set_req(32'h14); step(1);
        check("R4 pick", pick_idx, 4);
        pulse_start();
        check("R7 busy", xmit_busy, 1);
        prio_tb[7] = 63;
        set_req(32'h80); step(1);
        check("R7 frozen idx", pick_idx, 4);
        check("R7 frozen valid", pick_valid, 1);
        pulse_done();
        check("R8 req cleared", req_pending, 32'h84);
        check("R8 ack set", ack_status, 32'h10);
        check("R8 idle", xmit_busy, 0);
        check("R8 valid gap", pick_valid, 0);
        check("R10 flag", gflag, 1);
        step(1);
        check("R7 next pick", pick_idx, 7);
    endtask

    task automatic t_ack;
        do_reset();
        set_req(32'h08); step(1);
        pulse_start(); pulse_done();
        clr_ack(32'h00);
        check("R9 zero write", ack_status, 32'h08);
        clr_ack(32'h08);
        check("R9 cleared", ack_status, 32'h00);
        set_req(32'h08); step(1);
        pulse_start();
        xmit_done = 1; ack_clr_we = 1; ack_clr_data = 32'h08;
        step(1);
        xmit_done = 0; ack_clr_we = 0; ack_clr_data = '0;
        check("R9 set wins", ack_status, 32'h08);
    endtask

    task automatic t_irq;
        do_reset();
        irq_mask[1] = 0;
        set_req(32'h02); step(1);
        pulse_start(); pulse_done();
        check("R10 masked", gflag, 0);
        check("R10 ack still", ack_status, 32'h02);
        irq_mask[1] = 1;
        set_req(32'h02); step(1);
        pulse_start(); pulse_done();
        check("R10 unmasked", gflag, 1);
        gflag_clr = 1; step(1); gflag_clr = 0;
        check("R10 cleared", gflag, 0);
    endtask

    task automatic t_abort;
        do_reset();
        set_req(32'h20); step(1);
        pulse_start();
        pulse_abort();
        check("R11 idle", xmit_busy, 0);
        check("R11 req kept", req_pending, 32'h20);
        check("R11 no ack", ack_status, 0);
        step(1);
        check("R11 competes valid", pick_valid, 1);
        check("R11 competes idx", pick_idx, 5);
    endtask

    task automatic t_ignore;
        do_reset();
        pulse_start();
        check("R12 start ignored", xmit_busy, 0);
        set_req(32'h01);
        pulse_done();
        check("R12 done ignored req", req_pending, 32'h01);
        check("R12 done ignored ack", ack_status, 0);
        pulse_abort();
        check("R12 abort ignored", xmit_busy, 0);
        check("R12 abort ignored req", req_pending, 32'h01);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_set();
        t_prio();
        t_tie();
        t_qual();
        t_frame();
        t_ack();
        t_irq();
        t_abort();
        t_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule